// File: doc/BRIEF.md
# SPI Master with Status-Flag Handshake

This block is an SPI master that a processor drives through three byte-wide registers on a simple synchronous bus. The registers are control, status and data. Writing the data register is the only start command. The block then runs one 8-bit exchange in SPI mode 0, MSB first. The serial clock is the system clock divided by a factor that the control register selects. During the exchange the byte captured from `miso` is kept in a receive buffer, and reading the data register returns that buffer.

Completion is reported through one flag in the status register. Clearing that flag follows a two-step handshake: software first reads status while the flag is set, then touches the data register. An interrupt acknowledge also clears the flag. The interrupt request follows the flag, gated by a local enable bit and a global enable input. When the block is master and software has told it to watch the slave-select input, a low level on that input is treated as a bus conflict. The block reports the conflict through the same flag, sets a fault bit, leaves master mode and stops the exchange.

The block never drives a chip-select line. Framing, such as sending a 16-bit word as two bytes back to back, is left to software. The CPU bus has no handshake: every access completes in the cycle it is presented, and reads are combinational.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x01, which is divide-by-4 with every other bit clear. The status register (address 1) reads 0x00, and `sck`, `mosi` and `irq` are low.
- R2: When control bit 3 (master) is set and no exchange is running, a bus write to the data register (address 2) starts an 8-bit exchange. The exchange is mode 0 and MSB first: `mosi` holds the current bit while `sck` is high and changes only when `sck` falls. `sck` idles low.
- R3: Control bits 1:0 hold a rate select `s`. Each `sck` half period lasts 2^s system clocks, giving divide ratios of 2, 4, 8 and 16. From the clock edge that takes the data write to the edge that sets the completion flag is exactly 16·2^s cycles.
- R4: `miso` is sampled on each rising `sck` edge. The received byte is copied into the receive buffer on the same edge that sets status bit 7 (complete), and a data-register read returns that buffer.
- R5: Status bit 7 clears only after a status read that saw it set, followed by any data-register access, read or write. A data access with no such status read does not clear it, and neither do status reads alone or control accesses.
- R6: `irq` is high exactly when status bit 7, control bit 4 (interrupt enable) and `irq_gie` are all high.
- R7: A one-cycle pulse on `irq_ack` clears status bit 7.
- R8: A data write during an exchange is ignored: the byte on the wire and the byte received are unchanged. The write sets status bit 6 (write collision), and bit 6 clears through the same status-read-then-data-access sequence as bit 7.
- R9: When control bits 3 (master) and 2 (watch slave select) are both set and `ss_in`, after a two-stage synchronizer, is low, the block sets status bits 7 and 5 (fault), clears control bit 3 and aborts any exchange with `sck` low. With bit 2 clear, `ss_in` has no effect.
- R10: A data write while control bit 3 is clear starts nothing: `sck` does not toggle and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears complete flag |
| irq | output | 1 | Interrupt request |
| ss_in | input | 1 | Slave-select input, watched in master mode |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 8-bit data width and a two-stage slave-select synchronizer. A bench slave model shifts a computed reply byte onto `miso` and captures `mosi` on each rising `sck` edge. All 256 byte values are swept at the two fastest rate selects, and a strided subset is run at the two slowest. Each pass compares the exact frame length in cycles, the byte seen by the slave and the receive buffer against arithmetic expectations. Because the data width is small, the full clear handshake, collision, abort and interrupt gating sequences can each be driven one by one and read back through the registers.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int ST_DONE  = 7;
  localparam int ST_WCOL  = 6;
  localparam int ST_FAULT = 5;

  localparam int RATE_W = 2;

  typedef struct packed {
    logic [2:0]        rsvd;
    logic              irq_en;
    logic              master;
    logic              ss_watch;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{rsvd: 3'd0, irq_en: 1'b0, master: 1'b0,
                                   ss_watch: 1'b0, rate: 2'd1};
endpackage

// File: rtl/spi_rate_gen.sv
`timescale 1ns/1ps
module spi_rate_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half;
  logic [CNT_W-1:0] last;

  always_comb begin
    half = (CNT_W+1)'(1) << sel;
    last = CNT_W'(half - 1'b1);
    tick = run && (cnt == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         abort,
  input  logic         tick,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         done_pulse,
  output logic [W-1:0] rx
);
  localparam int BC_W = $clog2(W);

  logic [W-1:0]    sh;
  logic            samp;
  logic [BC_W-1:0] bitcnt;

  assign mosi       = sh[W-1];
  assign done_pulse = busy && tick && sck && (bitcnt == BC_W'(W-1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      samp   <= 1'b0;
      bitcnt <= '0;
      sck    <= 1'b0;
      busy   <= 1'b0;
      rx     <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= 1'b0;
    end else if (start && !busy) begin
      sh     <= tx;
      busy   <= 1'b1;
      bitcnt <= '0;
      sck    <= 1'b0;
    end else if (busy && tick) begin
      if (!sck) begin
        sck  <= 1'b1;
        samp <= miso;
      end else begin
        sck    <= 1'b0;
        sh     <= {sh[W-2:0], samp};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BC_W'(W-1)) begin
          busy <= 1'b0;
          rx   <= {sh[W-2:0], samp};
        end
      end
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
`timescale 1ns/1ps
module spi_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic ack,
  input  logic set_done,
  input  logic set_wcol,
  input  logic set_fault,
  input  logic irq_en,
  input  logic gie,
  output logic done,
  output logic wcol,
  output logic fault,
  output logic irq
);
  logic seen_done, seen_wcol, seen_fault;
  logic clr_done, clr_wcol, clr_fault;

  always_comb begin
    clr_done  = (data_acc && seen_done) || ack;
    clr_wcol  = data_acc && seen_wcol;
    clr_fault = data_acc && seen_fault;
    irq       = done && irq_en && gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      wcol <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= set_done  || (done  && !clr_done);
      wcol  <= set_wcol  || (wcol  && !clr_wcol);
      fault <= set_fault || (fault && !clr_fault);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_done  <= 1'b0;
      seen_wcol  <= 1'b0;
      seen_fault <= 1'b0;
    end else if (stat_rd) begin
      seen_done  <= done;
      seen_wcol  <= wcol;
      seen_fault <= fault;
    end else if (data_acc) begin
      seen_done  <= 1'b0;
      seen_wcol  <= 1'b0;
      seen_fault <= 1'b0;
    end else if (ack) begin
      seen_done  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs
  import spi_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_gie,
  input  logic              irq_ack,
  output logic              irq,
  input  logic              ss_in,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [SYNC_STAGES-1:0] ss_pipe;
  logic              ss_sync;
  logic              ctrl_wr, data_wr, data_acc, stat_rd;
  logic              start, busy, tick, done_pulse, fault_set;
  logic              done_flag, wcol_flag, fault_flag;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] status_word;

  // slave-select synchronizer, idles high
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_pipe[i] <= 1'b1;
        else        ss_pipe[i] <= (i == 0) ? ss_in : ss_pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign ss_sync = ss_pipe[SYNC_STAGES-1];

  always_comb begin
    ctrl_wr   = bus_sel && bus_we  && (bus_addr == ADDR_CTRL);
    data_wr   = bus_sel && bus_we  && (bus_addr == ADDR_DATA);
    data_acc  = bus_sel &&            (bus_addr == ADDR_DATA);
    stat_rd   = bus_sel && !bus_we && (bus_addr == ADDR_STAT);
    fault_set = ctrl_q.master && ctrl_q.ss_watch && !ss_sync;
    start     = data_wr && ctrl_q.master && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (fault_set) begin
      ctrl_q.master <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q      <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      ctrl_q.rsvd <= '0;
    end
  end

  spi_rate_gen #(.SEL_W(RATE_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .sel  (ctrl_q.rate),
    .tick (tick)
  );

  spi_shift_engine #(.W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx        (bus_wdata),
    .abort     (fault_set),
    .tick      (tick),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (busy),
    .done_pulse(done_pulse),
    .rx        (rx_buf)
  );

  spi_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .ack      (irq_ack),
    .set_done (done_pulse || fault_set),
    .set_wcol (data_wr && busy),
    .set_fault(fault_set),
    .irq_en   (ctrl_q.irq_en),
    .gie      (irq_gie),
    .done     (done_flag),
    .wcol     (wcol_flag),
    .fault    (fault_flag),
    .irq      (irq)
  );

  always_comb begin
    status_word           = '0;
    status_word[ST_DONE]  = done_flag;
    status_word[ST_WCOL]  = wcol_flag;
    status_word[ST_FAULT] = fault_flag;
    case (bus_addr)
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      ADDR_STAT: bus_rdata = status_word;
      ADDR_DATA: bus_rdata = rx_buf;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_master_regs_chk.sv
`timescale 1ns/1ps
module spi_master_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic              irq_ack,
  input logic              sck,
  input logic              mosi,
  input logic              busy,
  input logic              done_flag,
  input logic              wcol_flag,
  input logic              done_pulse,
  input logic              fault_set,
  input logic [DATA_W-1:0] rx_buf
);
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  assert_done_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(done_pulse || fault_set));

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_pulse) |-> $stable(rx_buf));

  assert_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(irq_ack || (bus_sel && bus_addr == 2'd2)));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done_pulse && !fault_set) |=> !done_flag);

  assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd2 && busy) |=> wcol_flag);

  assert_fault_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> (!busy && !sck));
endmodule

bind spi_master_regs spi_master_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .irq_ack   (irq_ack),
  .sck       (sck),
  .mosi      (mosi),
  .busy      (busy),
  .done_flag (done_flag),
  .wcol_flag (wcol_flag),
  .done_pulse(done_pulse),
  .fault_set (fault_set),
  .rx_buf    (rx_buf)
);

// File: tb/spi_master_regs_bench.sv
`timescale 1ns/1ps
module spi_master_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_gie = 1'b0, irq_ack = 1'b0, irq;
  logic       ss_in = 1'b1, sck, mosi, miso;

  int tests = 0;
  int fails = 0;
  logic [7:0] slv_tx = 8'd0;
  logic [7:0] slv_rx = 8'd0;
  int rises = 0;

  always #5 clk = ~clk;

  spi_master_regs u_spi_master_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_gie(irq_gie), .irq_ack(irq_ack), .irq(irq), .ss_in(ss_in),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // mode-0 slave model
  assign miso = slv_tx[7];
  always @(posedge sck) begin
    slv_rx <= {slv_rx[6:0], mosi};
    rises  <= rises + 1;
  end
  always @(negedge sck) slv_tx <= {slv_tx[6:0], 1'b0};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] reply(input int v);
    return 8'((v * 7 + 3) & 255);
  endfunction

  // one full exchange at rate select s, interrupt path enabled
  task automatic xfer(input int v, input int s);
    logic [7:0] r;
    int n;
    slv_tx = reply(v);
    wr(2'd2, 8'(v));
    n = 0;
    while (irq !== 1'b1 && n < 2000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk("R3 frame length", n, 16 << s);
    chk("R2 byte at slave", slv_rx, v);
    rd(2'd1, r); chk("R4 complete flag", r, 8'h80);
    rd(2'd2, r); chk("R4 receive buffer", r, reply(v));
    rd(2'd1, r); chk("R5 cleared by handshake", r, 8'h00);
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int snap;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, r); chk("R1 ctrl reset", r, 8'h01);
    rd(2'd1, r); chk("R1 status reset", r, 8'h00);
    chk("R1 sck", sck, 0); chk("R1 mosi", mosi, 0); chk("R1 irq", irq, 0);

    // R2 R3 R4 sweep over rate selects
    irq_gie = 1'b1;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'(8'h18 | s));
      for (int v = 0; v < 256; v += (s < 2) ? 1 : 5) xfer(v, s);
    end

    // R6 interrupt gating, R7 acknowledge
    wr(2'd0, 8'h18);
    slv_tx = 8'h5A; wr(2'd2, 8'hC3); idle(40);
    chk("R6 irq all enables", irq, 1);
    irq_gie = 1'b0; #1 chk("R6 irq gie low", irq, 0);
    irq_gie = 1'b1; #1 chk("R6 irq gie high", irq, 1);
    wr(2'd0, 8'h08); chk("R6 irq enable clear", irq, 0);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(2'd1, r); chk("R7 ack clears flag", r, 8'h00);

    // R5 clear sequence ordering
    slv_tx = 8'h21; wr(2'd2, 8'h42); idle(40);
    rd(2'd2, r); chk("R5 buffer", r, 8'h21);
    rd(2'd1, r); chk("R5 data read alone keeps flag", r, 8'h80);
    rd(2'd1, r); chk("R5 status read alone keeps flag", r, 8'h80);
    wr(2'd0, 8'h08);
    rd(2'd1, r); chk("R5 ctrl access keeps flag", r, 8'h80);
    rd(2'd2, r);
    rd(2'd1, r); chk("R5 handshake clears", r, 8'h00);

    // R8 write collision
    wr(2'd0, 8'h1B);
    slv_tx = 8'h3C; wr(2'd2, 8'h96); idle(20);
    wr(2'd2, 8'h11);
    idle(200);
    chk("R8 slave got first byte", slv_rx, 8'h96);
    rd(2'd1, r); chk("R8 collision bit", r, 8'hC0);
    rd(2'd2, r); chk("R8 buffer unchanged", r, 8'h3C);
    rd(2'd1, r); chk("R8 both bits cleared", r, 8'h00);

    // R9 ignored when not watching
    wr(2'd0, 8'h08);
    ss_in = 1'b0; idle(5);
    rd(2'd1, r); chk("R9 unwatched ss no flag", r, 8'h00);
    rd(2'd0, r); chk("R9 unwatched keeps master", r, 8'h08);
    ss_in = 1'b1; idle(3);

    // R9 fault aborts exchange
    wr(2'd0, 8'h0F);
    slv_tx = 8'hFF; wr(2'd2, 8'hAA); idle(20);
    ss_in = 1'b0; idle(4);
    chk("R9 sck low after abort", sck, 0);
    snap = rises; idle(60);
    chk("R9 no more sck", rises, snap);
    rd(2'd0, r); chk("R9 master cleared", r, 8'h07);
    rd(2'd1, r); chk("R9 fault status", r, 8'hA0);
    ss_in = 1'b1; idle(3);
    rd(2'd2, r);
    rd(2'd1, r); chk("R9 fault cleared", r, 8'h00);

    // R10 writes ignored outside master mode
    wr(2'd0, 8'h00);
    snap = rises; wr(2'd2, 8'h5F); idle(40);
    chk("R10 no sck", rises, snap);
    chk("R10 sck low", sck, 0);
    rd(2'd1, r); chk("R10 no status", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule